// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the bus side of a byte-wide NOR flash model. It watches active-low chip-select, write-strobe and read-strobe inputs together with a 19-bit address and an 8-bit data bus, all sampled on a system clock. A write cycle is a falling write strobe followed by a rising one while chip-select is low. The address is taken when the strobe falls and the data when it rises. The decoder follows multi-cycle unlock sequences and turns complete ones into one-cycle start pulses for an embedded operation engine. Each pulse carries the latched address and data.

Recognised commands are byte program (4 writes), chip erase and sector erase (6 writes), identifier mode (3 writes), and return-to-read. Return-to-read is either a single write of the reset code at any address or the same code at the end of the two unlock writes. In read mode a read returns a byte from a small register array that stands in for the flash array. Completed program and erase commands change that array. In identifier mode a read returns the maker code, the device code or a sector-protect flag. Identifier mode stays active until a reset command is written. A write that does not fit the expected next step is dropped, and the sequence restarts from the beginning.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset the block is in read mode: `dq_oe` is 0, no start pulse is active, and every array byte reads 0xFF.
- R2: `dq_oe` rises one clock after `ce_n` and `oe_n` are both sampled low, and is 0 one clock after either is sampled high.
- R3: A write-strobe pulse while `ce_n` is high is not a write cycle and does not advance any sequence.
- R4: Byte program is four writes: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, then target/data. The clock after the last strobe rises, `op_prog` is high for exactly one cycle with `op_addr`/`op_data` equal to that write. The array byte then reads old AND data.
- R5: Chip erase is 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x10. It gives one `op_chip_erase` pulse and sets every unprotected byte to 0xFF.
- R6: Sector erase is the same five leading writes followed by any address with data 0x30. It gives one `op_sect_erase` pulse carrying that address. Only the sector selected by address bits 18:16 becomes 0xFF.
- R7: After 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x90, a read with address bits 7:0 = 0x00 returns 0xAD and one with bits 7:0 = 0x01 returns 0x40.
- R8: In identifier mode, a read with address bits 7:0 = 0x02 returns the protect flag of sector address[18:16] on bit 0 and zero on bits 7:1. The default protect mask marks sectors 2 and 5. Other offsets return 0x00.
- R9: Identifier mode persists across reads and across writes that are not resets. Writing 0xF0 at any address, or 0xF0 after the two unlock writes, returns to read mode.
- R10: Only address bits 14:0 are compared in unlock, setup and confirm writes, so bits 18:15 may hold any value.
- R11: A write that does not match the expected next step discards the partial sequence. No pulse is issued and no mode is entered by the writes that follow it.
- R12: Program and erase leave bytes of protected sectors unchanged (start pulses are still issued).
- R13: The program target address is the address present when the write strobe falls. The data is the value present when it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | 19 | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data, valid while `dq_oe` is high |
| dq_oe | output | 1 | Output drive enable; low means high impedance |
| op_prog | output | 1 | One-cycle program start |
| op_chip_erase | output | 1 | One-cycle chip erase start |
| op_sect_erase | output | 1 | One-cycle sector erase start |
| op_addr | output | 19 | Address latched with the last start |
| op_data | output | 8 | Data latched with the last start |

## Verification
A sequence state that has gone wrong shows up at the end of a command. Either an expected start pulse is missing, or a pulse appears after an incomplete sequence, one clock after the final strobe rises. A wrong mode bit shows up on the very next read: identifier bytes appear where array data was expected, or the other way round. A wrong capture edge shows up as a mismatch between `op_addr` or `op_data` and the values driven at the strobe edges. Array update errors appear as stale or unprotected bytes on the first read-back after a program or erase.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int ADDR_W = 19;
    localparam int DATA_W = 8;
    localparam int CMD_AW = 15;
    localparam int SECT_W = 3;
    localparam int OFS_W  = 8;

    localparam logic [CMD_AW-1:0] UNLK_ADDR_A = 15'h5555;
    localparam logic [CMD_AW-1:0] UNLK_ADDR_B = 15'h2AAA;
    localparam logic [DATA_W-1:0] UNLK_DATA_A = 8'hAA;
    localparam logic [DATA_W-1:0] UNLK_DATA_B = 8'h55;

    localparam logic [DATA_W-1:0] CODE_PROG  = 8'hA0;
    localparam logic [DATA_W-1:0] CODE_ERASE = 8'h80;
    localparam logic [DATA_W-1:0] CODE_IDENT = 8'h90;
    localparam logic [DATA_W-1:0] CODE_RESET = 8'hF0;
    localparam logic [DATA_W-1:0] CODE_CHIP  = 8'h10;
    localparam logic [DATA_W-1:0] CODE_SECT  = 8'h30;

    localparam logic [OFS_W-1:0] OFS_MAKER = 8'h00;
    localparam logic [OFS_W-1:0] OFS_DEV   = 8'h01;
    localparam logic [OFS_W-1:0] OFS_PROT  = 8'h02;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_U1,
        SQ_U2,
        SQ_PROG,
        SQ_ERS,
        SQ_EU1,
        SQ_EU2
    } seq_e;

    typedef struct packed {
        logic              rise;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_evt_t;

    typedef struct packed {
        logic              prog;
        logic              chip;
        logic              sect;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } op_req_t;

    function automatic logic cyc_match(input logic [ADDR_W-1:0] a,
                                       input logic [DATA_W-1:0] d,
                                       input logic [CMD_AW-1:0] ea,
                                       input logic [DATA_W-1:0] ed);
        return (a[CMD_AW-1:0] == ea) && (d == ed);
    endfunction

    function automatic logic [SECT_W-1:0] sect_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: SECT_W];
    endfunction

endpackage

// File: rtl/fl_bus_strobe.sv
module fl_bus_strobe
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output wr_evt_t           evt
);
    logic              we_q;
    logic              armed;
    logic [ADDR_W-1:0] addr_lat;
    logic              fall;
    logic              rise;

    assign fall = we_q && !we_n && !ce_n;
    assign rise = !we_q && we_n && armed && !ce_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q     <= 1'b1;
            armed    <= 1'b0;
            addr_lat <= '0;
        end else begin
            we_q <= we_n;
            if (fall) begin
                armed    <= 1'b1;
                addr_lat <= addr;
            end else if (we_n && !we_q) begin
                armed <= 1'b0;
            end
        end
    end

    always_comb begin
        evt.rise = rise;
        evt.addr = addr_lat;
        evt.data = din;
    end
endmodule

// File: rtl/fl_cmd_seq.sv
module fl_cmd_seq
    import flash_cmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_evt_t evt,
    output logic    ident_mode,
    output op_req_t req
);
    seq_e state, nxt_state;
    logic nxt_ident;
    logic at_cmd_addr;
    logic unlock_a;
    logic unlock_b;

    assign at_cmd_addr = (evt.addr[CMD_AW-1:0] == UNLK_ADDR_A);
    assign unlock_a    = cyc_match(evt.addr, evt.data, UNLK_ADDR_A, UNLK_DATA_A);
    assign unlock_b    = cyc_match(evt.addr, evt.data, UNLK_ADDR_B, UNLK_DATA_B);

    always_comb begin
        nxt_state = state;
        nxt_ident = ident_mode;
        req       = '0;
        req.addr  = evt.addr;
        req.data  = evt.data;
        if (evt.rise) begin
            if (state == SQ_PROG) begin
                req.prog  = 1'b1;
                nxt_state = SQ_IDLE;
            end else if (evt.data == CODE_RESET) begin
                nxt_state = SQ_IDLE;
                nxt_ident = 1'b0;
            end else begin
                unique case (state)
                    SQ_IDLE: nxt_state = unlock_a ? SQ_U1 : SQ_IDLE;
                    SQ_U1:   nxt_state = unlock_b ? SQ_U2 : SQ_IDLE;
                    SQ_U2: begin
                        nxt_state = SQ_IDLE;
                        if (at_cmd_addr) begin
                            if (evt.data == CODE_PROG)       nxt_state = SQ_PROG;
                            else if (evt.data == CODE_ERASE) nxt_state = SQ_ERS;
                            else if (evt.data == CODE_IDENT) nxt_ident = 1'b1;
                        end
                    end
                    SQ_ERS:  nxt_state = unlock_a ? SQ_EU1 : SQ_IDLE;
                    SQ_EU1:  nxt_state = unlock_b ? SQ_EU2 : SQ_IDLE;
                    SQ_EU2: begin
                        nxt_state = SQ_IDLE;
                        if (at_cmd_addr && evt.data == CODE_CHIP) req.chip = 1'b1;
                        else if (evt.data == CODE_SECT)           req.sect = 1'b1;
                    end
                    default: nxt_state = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            ident_mode <= 1'b0;
        end else begin
            state      <= nxt_state;
            ident_mode <= nxt_ident;
        end
    end
endmodule

// File: rtl/fl_array_model.sv
module fl_array_model
    import flash_cmd_pkg::*;
#(
    parameter int                      WORD_BITS = 3,
    parameter logic [(1<<SECT_W)-1:0]  PROT_MASK = 8'b0010_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  op_req_t           req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W   = SECT_W + WORD_BITS;
    localparam int ENTRIES = 1 << IDX_W;

    logic [DATA_W-1:0] mem [ENTRIES];
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic [SECT_W-1:0] ers_sect;

    assign wr_idx   = {sect_of(req.addr), req.addr[WORD_BITS-1:0]};
    assign rd_idx   = {sect_of(rd_addr), rd_addr[WORD_BITS-1:0]};
    assign ers_sect = sect_of(req.addr);
    assign rd_data  = mem[rd_idx];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cell
        localparam logic [SECT_W-1:0] CELL_SECT = SECT_W'(i >> WORD_BITS);
        localparam logic              CELL_PROT = PROT_MASK[i >> WORD_BITS];
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '1;
            end else if (!CELL_PROT) begin
                if (req.chip || (req.sect && ers_sect == CELL_SECT))
                    mem[i] <= '1;
                else if (req.prog && wr_idx == IDX_W'(i))
                    mem[i] <= mem[i] & req.data;
            end
        end
    end
endmodule

// File: rtl/fl_read_path.sv
module fl_read_path
    import flash_cmd_pkg::*;
#(
    parameter logic [(1<<SECT_W)-1:0] PROT_MASK  = 8'b0010_0100,
    parameter logic [DATA_W-1:0]      MAKER_CODE = 8'hAD,
    parameter logic [DATA_W-1:0]      DEV_CODE   = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              ident_mode,
    input  logic [SECT_W-1:0] rd_sect,
    input  logic [OFS_W-1:0]  rd_ofs,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic [DATA_W-1:0] id_val;
    logic              drive;

    assign drive = !ce_n && !oe_n;

    always_comb begin
        unique case (rd_ofs)
            OFS_MAKER: id_val = MAKER_CODE;
            OFS_DEV:   id_val = DEV_CODE;
            OFS_PROT:  id_val = {{(DATA_W-1){1'b0}}, PROT_MASK[rd_sect]};
            default:   id_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_oe  <= 1'b0;
            dq_out <= '0;
        end else begin
            dq_oe  <= drive;
            dq_out <= drive ? (ident_mode ? id_val : arr_data) : '0;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int                     WORD_BITS  = 3,
    parameter logic [(1<<SECT_W)-1:0] PROT_MASK  = 8'b0010_0100,
    parameter logic [DATA_W-1:0]      MAKER_CODE = 8'hAD,
    parameter logic [DATA_W-1:0]      DEV_CODE   = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              op_prog,
    output logic              op_chip_erase,
    output logic              op_sect_erase,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);
    wr_evt_t           evt;
    op_req_t           req;
    logic              ident_mode;
    logic [DATA_W-1:0] arr_data;

    fl_bus_strobe u_strobe (
        .clk  (clk),
        .rst  (rst),
        .ce_n (ce_n),
        .we_n (we_n),
        .addr (addr),
        .din  (dq_in),
        .evt  (evt)
    );

    fl_cmd_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .ident_mode (ident_mode),
        .req        (req)
    );

    fl_array_model #(
        .WORD_BITS (WORD_BITS),
        .PROT_MASK (PROT_MASK)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .rd_addr (addr),
        .rd_data (arr_data)
    );

    fl_read_path #(
        .PROT_MASK  (PROT_MASK),
        .MAKER_CODE (MAKER_CODE),
        .DEV_CODE   (DEV_CODE)
    ) u_read (
        .clk        (clk),
        .rst        (rst),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .ident_mode (ident_mode),
        .rd_sect    (sect_of(addr)),
        .rd_ofs     (addr[OFS_W-1:0]),
        .arr_data   (arr_data),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_prog       <= 1'b0;
            op_chip_erase <= 1'b0;
            op_sect_erase <= 1'b0;
            op_addr       <= '0;
            op_data       <= '0;
        end else begin
            op_prog       <= req.prog;
            op_chip_erase <= req.chip;
            op_sect_erase <= req.sect;
            if (req.prog || req.chip || req.sect) begin
                op_addr <= req.addr;
                op_data <= req.data;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
    input logic clk,
    input logic rst,
    input logic ce_n,
    input logic oe_n,
    input logic dq_oe,
    input logic op_prog,
    input logic op_chip_erase,
    input logic op_sect_erase
);
    // R1: the cycle after reset shows no drive and no start
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!dq_oe && !op_prog && !op_chip_erase && !op_sect_erase));

    // R2: deselect or read strobe high gives high impedance next cycle
    p_hiz_r2: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |=> !dq_oe);

    // R2: both strobes low gives drive next cycle
    p_drive_r2: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n) |=> dq_oe);

    // R3: a start needs chip select low at the completing edge
    p_start_selected_r3: assert property (@(posedge clk) disable iff (rst)
        (op_prog || op_chip_erase || op_sect_erase) |-> !$past(ce_n));

    // R4: at most one start kind at a time
    p_one_start_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({op_prog, op_chip_erase, op_sect_erase}));

    // R4: program start lasts a single cycle
    p_prog_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        op_prog |=> !op_prog);

    // R5: chip erase start lasts a single cycle
    p_chip_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        op_chip_erase |=> !op_chip_erase);

    // R6: sector erase start lasts a single cycle
    p_sect_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        op_sect_erase |=> !op_sect_erase);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ce_n          (ce_n),
    .oe_n          (oe_n),
    .dq_oe         (dq_oe),
    .op_prog       (op_prog),
    .op_chip_erase (op_chip_erase),
    .op_sect_erase (op_sect_erase)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [18:0] addr = '0;
    logic [7:0]  dq_in = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;
    logic        op_prog;
    logic        op_chip_erase;
    logic        op_sect_erase;
    logic [18:0] op_addr;
    logic [7:0]  op_data;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_decoder uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .op_prog(op_prog), .op_chip_erase(op_chip_erase),
        .op_sect_erase(op_sect_erase), .op_addr(op_addr), .op_data(op_data)
    );

    typedef struct packed {
        logic        rd;
        logic [18:0] a;
        logic [7:0]  d;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 19'h00000, 8'h00, 8'hFF, 4'd1},   // R1 array erased
        '{1'b0, 19'h05555, 8'hAA, 8'h00, 4'd7},
        '{1'b0, 19'h02AAA, 8'h55, 8'h00, 4'd7},
        '{1'b0, 19'h05555, 8'h90, 8'h00, 4'd7},
        '{1'b1, 19'h00000, 8'h00, 8'hAD, 4'd7},   // R7 maker
        '{1'b1, 19'h00001, 8'h00, 8'h40, 4'd7},   // R7 device
        '{1'b1, 19'h20002, 8'h00, 8'h01, 4'd8},   // R8 sector 2 protected
        '{1'b1, 19'h30002, 8'h00, 8'h00, 4'd8},   // R8 sector 3 open
        '{1'b1, 19'h50002, 8'h00, 8'h01, 4'd8},   // R8 sector 5 protected
        '{1'b1, 19'h00003, 8'h00, 8'h00, 4'd8},   // R8 other offset
        '{1'b0, 19'h00000, 8'h12, 8'h00, 4'd9},
        '{1'b1, 19'h00001, 8'h00, 8'h40, 4'd9},   // R9 persists
        '{1'b0, 19'h05555, 8'hAA, 8'h00, 4'd9},
        '{1'b0, 19'h02AAA, 8'h55, 8'h00, 4'd9},
        '{1'b0, 19'h05555, 8'hF0, 8'h00, 4'd9},
        '{1'b1, 19'h00001, 8'h00, 8'hFF, 4'd9},   // R9 long reset
        '{1'b0, 19'h7D555, 8'hAA, 8'h00, 4'd10},
        '{1'b0, 19'h7AAAA, 8'h55, 8'h00, 4'd10},
        '{1'b0, 19'h7D555, 8'h90, 8'h00, 4'd10},
        '{1'b1, 19'h00000, 8'h00, 8'hAD, 4'd10},  // R10 high bits ignored
        '{1'b0, 19'h12345, 8'hF0, 8'h00, 4'd9},
        '{1'b1, 19'h00000, 8'h00, 8'hFF, 4'd9},   // R9 single reset
        '{1'b0, 19'h05555, 8'hAA, 8'h00, 4'd11},
        '{1'b0, 19'h02AAB, 8'h55, 8'h00, 4'd11},
        '{1'b0, 19'h05555, 8'h90, 8'h00, 4'd11},
        '{1'b1, 19'h00000, 8'h00, 8'hFF, 4'd11},  // R11 bad unlock
        '{1'b0, 19'h05555, 8'hAA, 8'h00, 4'd11},
        '{1'b0, 19'h02AAA, 8'h55, 8'h00, 4'd11},
        '{1'b0, 19'h05555, 8'h77, 8'h00, 4'd11},
        '{1'b1, 19'h00001, 8'h00, 8'hFF, 4'd11}   // R11 bad setup code
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [18:0] a, input logic [7:0] d);
        addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic bus_write_split(input logic [18:0] a_fall, input logic [18:0] a_rise,
                                   input logic [7:0] d_fall, input logic [7:0] d_rise);
        addr = a_fall; dq_in = d_fall; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        addr = a_rise; dq_in = d_rise; we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic bus_read(input logic [18:0] a, output logic [7:0] d, output logic oe);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        d = dq_out; oe = dq_oe;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic read_chk(input string tag, input logic [18:0] a, input logic [7:0] exp);
        logic [7:0] d;
        logic       oe;
        bus_read(a, d, oe);
        chk(tag, {23'd0, oe, d}, {23'd0, 1'b1, exp});
    endtask

    task automatic unlock(input logic [7:0] code);
        bus_write(19'h05555, 8'hAA);
        bus_write(19'h02AAA, 8'h55);
        bus_write(19'h05555, code);
    endtask

    task automatic erase_lead;
        unlock(8'h80);
        bus_write(19'h05555, 8'hAA);
        bus_write(19'h02AAA, 8'h55);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset oe", {31'd0, dq_oe}, 0);
        chk("R1 reset pulses", {29'd0, op_prog, op_chip_erase, op_sect_erase}, 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) begin
                logic [7:0] d;
                logic       oe;
                bus_read(VEC[i].a, d, oe);
                total++;
                if (!oe || d !== VEC[i].exp) begin
                    bad++;
                    $display("FAIL R%0d vector %0d actual=%0h/%0b expected=%0h/1",
                             VEC[i].req, i, d, oe, VEC[i].exp);
                end
            end else begin
                bus_write(VEC[i].a, VEC[i].d);
            end
        end

        // R2 output enable gating
        ce_n = 1'b0; oe_n = 1'b1; @(negedge clk);
        chk("R2 oe_n high", {31'd0, dq_oe}, 0);
        ce_n = 1'b1; oe_n = 1'b0; @(negedge clk);
        chk("R2 ce_n high", {31'd0, dq_oe}, 0);
        ce_n = 1'b0; oe_n = 1'b0; @(negedge clk);
        chk("R2 both low", {31'd0, dq_oe}, 1);
        ce_n = 1'b1; oe_n = 1'b1; @(negedge clk);
        chk("R2 released", {31'd0, dq_oe}, 0);

        // R4 program and single pulse
        unlock(8'hA0);
        chk("R4 setup no pulse", {31'd0, op_prog}, 0);
        bus_write(19'h10003, 8'h5A);
        chk("R4 prog pulse", {29'd0, op_prog, op_chip_erase, op_sect_erase}, 3'b100);
        chk("R4 op_addr", {13'd0, op_addr}, 32'h10003);
        chk("R4 op_data", {24'd0, op_data}, 32'h5A);
        @(negedge clk);
        chk("R4 pulse width", {31'd0, op_prog}, 0);
        read_chk("R4 readback", 19'h10003, 8'h5A);
        unlock(8'hA0);
        bus_write(19'h10003, 8'h0F);
        read_chk("R4 and-merge", 19'h10003, 8'h0A);

        // R13 capture edges
        unlock(8'hA0);
        bus_write_split(19'h10005, 19'h10006, 8'h11, 8'h3C);
        chk("R13 addr at fall", {13'd0, op_addr}, 32'h10005);
        chk("R13 data at rise", {24'd0, op_data}, 32'h3C);
        read_chk("R13 target byte", 19'h10005, 8'h3C);
        read_chk("R13 other byte", 19'h10006, 8'hFF);

        // R3 deselected strobe is not a write
        addr = 19'h05555; dq_in = 8'hAA; ce_n = 1'b1; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        bus_write(19'h02AAA, 8'h55);
        bus_write(19'h05555, 8'hA0);
        bus_write(19'h10007, 8'h00);
        chk("R3 no prog", {31'd0, op_prog}, 0);
        read_chk("R3 byte intact", 19'h10007, 8'hFF);

        // R6 sector erase
        unlock(8'hA0);
        bus_write(19'h00001, 8'h33);
        erase_lead();
        chk("R6 lead no pulse", {29'd0, op_prog, op_chip_erase, op_sect_erase}, 0);
        bus_write(19'h10000, 8'h30);
        chk("R6 sect pulse", {29'd0, op_prog, op_chip_erase, op_sect_erase}, 3'b001);
        chk("R6 sect addr", {13'd0, op_addr}, 32'h10000);
        read_chk("R6 erased a", 19'h10003, 8'hFF);
        read_chk("R6 erased b", 19'h10005, 8'hFF);
        read_chk("R6 other sector", 19'h00001, 8'h33);

        // R12 protected sector
        unlock(8'hA0);
        bus_write(19'h20001, 8'h00);
        chk("R12 pulse still issued", {31'd0, op_prog}, 1);
        read_chk("R12 protected intact", 19'h20001, 8'hFF);

        // R11 bad confirm
        erase_lead();
        bus_write(19'h05555, 8'h20);
        chk("R11 no start", {29'd0, op_prog, op_chip_erase, op_sect_erase}, 0);
        read_chk("R11 data kept", 19'h00001, 8'h33);

        // R5 chip erase
        unlock(8'hA0);
        bus_write(19'h30002, 8'h44);
        read_chk("R5 pre", 19'h30002, 8'h44);
        erase_lead();
        bus_write(19'h05555, 8'h10);
        chk("R5 chip pulse", {29'd0, op_prog, op_chip_erase, op_sect_erase}, 3'b010);
        read_chk("R5 erased a", 19'h00001, 8'hFF);
        read_chk("R5 erased b", 19'h30002, 8'hFF);

        // R1 reset leaves identifier mode
        unlock(8'h90);
        read_chk("R1 ident before reset", 19'h00000, 8'hAD);
        unlock(8'hA0);
        bus_write(19'h00004, 8'h00);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 oe after reset", {31'd0, dq_oe}, 0);
        read_chk("R1 read mode after reset", 19'h00000, 8'hFF);
        read_chk("R1 array cleared", 19'h00004, 8'hFF);

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule